// File: doc/BRIEF.md
# Edge-Triggered Interrupt Port

This block is one 8-bit general-purpose port with its data and direction registers, extended with edge-sensitive interrupt detection on every pin. Each pin is an input when its direction bit is clear and an output when set; an output pin drives the stored data bit onto the pad. A small register interface writes and reads the data latch, the direction register and an interrupt-enable register with one bit per pin.

The pad inputs pass through a two-flop synchronizer before edge detection. The edge polarity is fixed per pin: some pins react to a rising edge and the rest to a falling edge. A qualifying edge sets the pending latch of the vector that owns the pin. A qualifying edge needs the pin's enable bit set and the pin in input mode. Pins in one vector group share that latch (logical OR). A request leaves the block only while the global interrupt mask input is low. A request that arrives while masked stays pending until the mask drops or software clears it. Any qualifying edge also raises a wake indication for leaving a halted state, whatever the mask.

Top module: `eint_port`

## Requirements
- R1: After reset, the direction, data and enable registers hold 0, `pad_oe` and `pad_out` are 0 and no vector is pending (`irq_req` is 0).
- R2: `pad_oe` equals the direction register and `pad_out` equals the data latch, each one cycle after the register write.
- R3: `reg_rdata` is combinational on `reg_addr`. Address 0 returns, per bit, the data latch where the direction bit is 1 and the synchronized pad level where it is 0. Address 1 returns the direction register. Address 2 returns the enable register. Address 3 returns 0.
- R4: Port bits 0, 1, 4 and 5 register an interrupt on a rising pad edge only.
- R5: Port bits 2, 3, 6 and 7 register an interrupt on a falling pad edge only.
- R6: An edge on a pin whose enable bit is 0 sets no pending latch and does not raise `halt_wake`.
- R7: An edge on a pin whose direction bit is 1 sets no pending latch and does not raise `halt_wake`.
- R8: `irq_req[v]` is the pending latch of vector v gated by `irq_mask` low. A latch set while masked is kept and appears on `irq_req` as soon as the mask is 0.
- R9: Vector 0 collects port bits 0 to 3 and vector 1 collects bits 4 to 7, ORed into one latch each.
- R10: A 1 on `clr_pend[v]` clears the vector's latch at the next edge, unless a qualifying edge for that vector is detected in the same cycle, in which case the latch stays set.
- R11: `halt_wake` is high during the cycle in which any qualifying edge is detected, independent of `irq_mask`. This is the cycle after the second clock edge following the pad change. The latch is set and `irq_req` is visible after the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad drive value (data latch) |
| pad_oe | output | 8 | Pad output enable (direction register) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks requests |
| clr_pend | input | 2 | Per-vector pending clear strobe |
| irq_req | output | 2 | Per-vector interrupt request |
| halt_wake | output | 1 | Wake indication on any qualifying edge |

## Verification
A pad change driven between clock edges reaches the second synchronizer flop after two rising edges. `halt_wake` and the address-0 read value therefore change in the cycle that follows. The pending latch and `irq_req` change one edge later. Register writes appear on `pad_oe`, `pad_out` and `reg_rdata` one edge after the strobe. Mask changes reach `irq_req` in the same cycle. The bench drives all inputs on the falling edge and advances a behavioural model on each rising edge. It compares every output at the next falling edge. The directed checks wait exactly these counts before sampling.

// File: rtl/eint_pkg.sv
// Package: shared register-select encoding for the interrupt port.
// Assumes a 2-bit register address.
package eint_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_NONE = 2'd3
    } eint_sel_e;
endpackage

// File: rtl/eint_sync.sv
// Two-flop pad synchronizer plus one history stage for edge detection.
// Assumes pad_in is asynchronous to clk; reset is synchronous active-low.
module eint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Purpose: shift pad levels through meta, sync and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign lvl   = sync_q;
    assign lvl_d = hist_q;
endmodule

// File: rtl/eint_qual.sv
// Per-pin edge detector with fixed polarity and enable/direction gating.
// Assumes RISE_SEL bit = 1 selects rising edge for that pin, 0 falling.
module eint_qual #(
    parameter int           W        = 8,
    parameter logic [W-1:0] RISE_SEL = 8'h33
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_d,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] ien,
    output logic [W-1:0] qual
);
    for (genvar b = 0; b < W; b++) begin : g_pin
        logic edge_seen;
        if (RISE_SEL[b]) begin : g_rise
            assign edge_seen = lvl[b] & ~lvl_d[b];
        end else begin : g_fall
            assign edge_seen = ~lvl[b] & lvl_d[b];
        end
        // Purpose: accept the edge only for enabled input pins.
        always_comb qual[b] = edge_seen & ien[b] & ~dir[b];
    end
endmodule

// File: rtl/eint_pend.sv
// Per-vector pending latches: OR of grouped pin hits, set beats clear,
// requests gated by the global mask. Assumes W is a multiple of GRP.
module eint_pend #(
    parameter int W   = 8,
    parameter int GRP = 4,
    parameter int NV  = W / GRP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  qual,
    input  logic [NV-1:0] clr,
    input  logic          mask,
    output logic [NV-1:0] vec_hit,
    output logic [NV-1:0] pend,
    output logic [NV-1:0] irq,
    output logic          wake
);
    logic [NV-1:0] pend_q;

    for (genvar v = 0; v < NV; v++) begin : g_vec
        // Purpose: OR the pin hits belonging to this vector.
        always_comb vec_hit[v] = |qual[v*GRP +: GRP];

        // Purpose: hold the pending latch; a new hit overrides a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q[v] <= 1'b0;
            else if (vec_hit[v]) pend_q[v] <= 1'b1;
            else if (clr[v])     pend_q[v] <= 1'b0;
        end
    end

    // Purpose: drive requests and the wake indication.
    always_comb begin
        irq  = mask ? '0 : pend_q;
        wake = |qual;
    end

    assign pend = pend_q;
endmodule

// File: rtl/eint_regs.sv
// Data, direction and interrupt-enable registers with read mux.
// Assumes single-cycle writes; reads are combinational.
module eint_regs
    import eint_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_lvl,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dr,
    output logic [W-1:0] dir,
    output logic [W-1:0] ien
);
    eint_sel_e sel;
    assign sel = eint_sel_e'(addr);

    // Purpose: update the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr  <= '0;
            dir <= '0;
            ien <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA: dr  <= wdata;
                SEL_DIR:  dir <= wdata;
                SEL_IEN:  ien <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: select read data; data reads mix latch and pad per bit.
    always_comb begin
        case (sel)
            SEL_DATA: rdata = (dr & dir) | (pin_lvl & ~dir);
            SEL_DIR:  rdata = dir;
            SEL_IEN:  rdata = ien;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/eint_port.sv
// Top: 8-bit port with edge-triggered interrupts grouped into vectors.
// Assumes synchronous active-low reset and asynchronous pad inputs.
module eint_port #(
    parameter int             PORT_W   = 8,
    parameter int             GRP_SIZE = 4,
    parameter logic [PORT_W-1:0] RISE_SEL = 8'h33,
    localparam int            NUM_VEC  = PORT_W / GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_W-1:0]  pad_in,
    output logic [PORT_W-1:0]  pad_out,
    output logic [PORT_W-1:0]  pad_oe,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [PORT_W-1:0]  reg_wdata,
    output logic [PORT_W-1:0]  reg_rdata,
    input  logic               irq_mask,
    input  logic [NUM_VEC-1:0] clr_pend,
    output logic [NUM_VEC-1:0] irq_req,
    output logic               halt_wake
);
    logic [PORT_W-1:0]  lvl, lvl_d, dr_q, dir_q, ien_q, qual;
    logic [NUM_VEC-1:0] vec_hit, pend_q;

    eint_sync #(.W(PORT_W)) sync_i (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(lvl), .lvl_d(lvl_d)
    );

    eint_regs #(.W(PORT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .pin_lvl(lvl), .rdata(reg_rdata),
        .dr(dr_q), .dir(dir_q), .ien(ien_q)
    );

    eint_qual #(.W(PORT_W), .RISE_SEL(RISE_SEL)) qual_i (
        .lvl(lvl), .lvl_d(lvl_d), .dir(dir_q), .ien(ien_q), .qual(qual)
    );

    eint_pend #(.W(PORT_W), .GRP(GRP_SIZE), .NV(NUM_VEC)) pend_i (
        .clk(clk), .rst_n(rst_n), .qual(qual), .clr(clr_pend), .mask(irq_mask),
        .vec_hit(vec_hit), .pend(pend_q), .irq(irq_req), .wake(halt_wake)
    );

    assign pad_out = dr_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/eint_port_chk.sv
// Checker bound to eint_port: temporal properties on ports and latches.
module eint_port_chk #(
    parameter int PW = 8,
    parameter int NV = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] pad_oe,
    input logic [NV-1:0] irq_req,
    input logic          irq_mask,
    input logic          halt_wake,
    input logic [NV-1:0] clr_pend,
    input logic [NV-1:0] vec_hit,
    input logic [NV-1:0] pend_q
);
    // R1: state is clean on the first cycle out of reset
    a_r1_reset_clean: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && irq_req == '0));

    // R8: no request leaves while masked
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> irq_req == '0);

    // R11: a wake pulse is followed by a pending latch
    a_r11_wake_latches: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wake |=> (|pend_q));

    // R7: with every pin an output no wake can occur
    a_r7_outputs_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe == '1) |-> !halt_wake);

    // R10: a clear without a competing hit empties the latch
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_pend & ~vec_hit)) |=> ((pend_q & $past(clr_pend & ~vec_hit)) == '0));

    // R10: a hit keeps the latch set even against a clear
    a_r10_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|vec_hit) |=> ((pend_q & $past(vec_hit)) == $past(vec_hit)));
endmodule

bind eint_port eint_port_chk #(.PW(PORT_W), .NV(NUM_VEC)) chk_i (
    .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .irq_req(irq_req),
    .irq_mask(irq_mask), .halt_wake(halt_wake), .clr_pend(clr_pend),
    .vec_hit(vec_hit), .pend_q(pend_q)
);

// File: tb/eint_port_tb_top.sv
module eint_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, reg_rdata;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic       irq_mask = 1'b0;
    logic [1:0] clr_pend = '0;
    logic [1:0] irq_req;
    logic       halt_wake;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eint_port dut_i (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_mask(irq_mask),
        .clr_pend(clr_pend), .irq_req(irq_req), .halt_wake(halt_wake)
    );

    // Behavioural reference: pad history, registers, pending bits
    logic [7:0] m_s1, m_s2, m_s3, m_dr, m_ddr, m_ien;
    logic [1:0] m_pend;
    localparam logic [7:0] RISING = 8'h33;

    function automatic logic [7:0] m_hits();
        logic [7:0] h;
        for (int b = 0; b < 8; b++) begin
            logic e;
            e = RISING[b] ? (m_s2[b] && !m_s3[b]) : (!m_s2[b] && m_s3[b]);
            h[b] = e && m_ien[b] && !m_ddr[b];
        end
        return h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_dr = 0; m_ddr = 0; m_ien = 0;
            m_pend = 0;
        end else begin
            logic [7:0] h;
            logic [1:0] s;
            h = m_hits();
            s = {|h[7:4], |h[3:0]};
            m_pend = s | (m_pend & ~clr_pend);
            if (reg_wr_en) begin
                if (reg_addr == 2'd0) m_dr = reg_wdata;
                if (reg_addr == 2'd1) m_ddr = reg_wdata;
                if (reg_addr == 2'd2) m_ien = reg_wdata;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] rd;
            case (reg_addr)
                2'd0: rd = (m_dr & m_ddr) | (m_s2 & ~m_ddr);
                2'd1: rd = m_ddr;
                2'd2: rd = m_ien;
                default: rd = 8'h00;
            endcase
            chk("R2 model pad_oe", pad_oe, m_ddr);
            chk("R2 model pad_out", pad_out, m_dr);
            chk("R3 model rdata", reg_rdata, rd);
            chk("R8 model irq_req", {6'd0, irq_req}, {6'd0, irq_mask ? 2'b00 : m_pend});
            chk("R11 model halt_wake", {7'd0, halt_wake}, {7'd0, |m_hits()});
        end
    end

    task automatic nclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        nclk(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic clear(logic [1:0] v);
        clr_pend = v;
        nclk(1);
        clr_pend = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        nclk(4);
        rst_n = 1'b1;
        nclk(1);
        // R1
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 irq_req", {6'd0, irq_req}, 8'h00);
        reg_addr = 2'd1; #1;
        chk("R1 dir reads 0", reg_rdata, 8'h00);
        nclk(1);

        wr(2'd2, 8'hFF);
        // R4 and R11: rising on bit0
        pad_in[0] = 1'b1;
        nclk(2);
        chk("R11 wake in detect cycle", {7'd0, halt_wake}, 8'd1);
        nclk(1);
        chk("R4 rising bit0 -> vec0", {6'd0, irq_req}, 8'd1);
        clear(2'b01);
        chk("R10 clear empties vec0", {6'd0, irq_req}, 8'd0);

        // R5: falling pin ignores rising edge, reacts to falling
        pad_in[2] = 1'b1;
        nclk(2);
        chk("R5 no wake on rising", {7'd0, halt_wake}, 8'd0);
        nclk(1);
        chk("R5 no irq on rising", {6'd0, irq_req}, 8'd0);
        pad_in[2] = 1'b0;
        nclk(3);
        chk("R5 falling bit2 -> vec0", {6'd0, irq_req}, 8'd1);
        clear(2'b01);

        // R9: grouping
        pad_in[5] = 1'b1;
        nclk(3);
        chk("R9 bit5 -> vec1", {6'd0, irq_req}, 8'd2);
        pad_in[3] = 1'b1;
        nclk(3);
        pad_in[3] = 1'b0;
        nclk(3);
        chk("R9 both vectors", {6'd0, irq_req}, 8'd3);
        clear(2'b11);
        chk("R10 clear both", {6'd0, irq_req}, 8'd0);

        // R6: disabled pin
        wr(2'd2, 8'hFE);
        pad_in[0] = 1'b0;
        nclk(3);
        pad_in[0] = 1'b1;
        nclk(2);
        chk("R6 disabled no wake", {7'd0, halt_wake}, 8'd0);
        nclk(1);
        chk("R6 disabled no irq", {6'd0, irq_req}, 8'd0);
        wr(2'd2, 8'hFF);

        // R7: output pin
        wr(2'd1, 8'h10);
        chk("R2 pad_oe follows dir", pad_oe, 8'h10);
        pad_in[4] = 1'b1;
        nclk(2);
        chk("R7 output no wake", {7'd0, halt_wake}, 8'd0);
        nclk(1);
        chk("R7 output no irq", {6'd0, irq_req}, 8'd0);
        wr(2'd1, 8'h00);
        pad_in[4] = 1'b0;
        nclk(3);

        // R8: masked request kept
        irq_mask = 1'b1;
        pad_in[1] = 1'b1;
        nclk(2);
        chk("R11 wake while masked", {7'd0, halt_wake}, 8'd1);
        nclk(1);
        chk("R8 masked no irq", {6'd0, irq_req}, 8'd0);
        nclk(2);
        irq_mask = 1'b0; #1;
        chk("R8 pending appears on unmask", {6'd0, irq_req}, 8'd1);
        nclk(1);
        clear(2'b01);

        // R10: hit in the clear cycle wins
        pad_in[6] = 1'b1;
        nclk(3);
        pad_in[6] = 1'b0;
        nclk(2);
        clr_pend = 2'b10;
        nclk(1);
        clr_pend = 2'b00;
        chk("R10 hit beats clear", {6'd0, irq_req}, 8'd2);
        clear(2'b10);

        // R2/R3: mixed direction read-back
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'hA5);
        pad_in = 8'h3C;
        nclk(3);
        chk("R2 pad_out latch", pad_out, 8'hA5);
        reg_addr = 2'd0; #1;
        chk("R3 data mixed read", reg_rdata, 8'h35);
        reg_addr = 2'd1; #1;
        chk("R3 dir read", reg_rdata, 8'h0F);
        reg_addr = 2'd2; #1;
        chk("R3 ien read", reg_rdata, 8'hFF);
        reg_addr = 2'd3; #1;
        chk("R3 spare reads 0", reg_rdata, 8'h00);
        nclk(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule